// File: doc/BRIEF.md
# Maskable Calendar Alarm with Interrupt Flag

This block watches the running calendar counters of a real-time clock and raises an interrupt when they reach a programmed alarm. The time counter is outside the block. On every one-second tick it presents the current seconds, minutes, hours and date in BCD. The block holds four alarm registers, one per field. Each register has a mask bit that makes its field match unconditionally. Masking fields gives four match modes: once per day, once per hour, once per minute, or once per second when all four are masked.

A small host register port gives access to the alarm registers, an alarm interrupt enable in the second control register, and a status register in the first control register. The status register holds a time-match flag and a summary interrupt-request flag. Reading the status register clears both flags. The interrupt output is a level that follows the summary flag.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset all four alarm registers, the enable bit and both status flags are 0, and irq_o is low.
- R2: Alarm registers sit at offsets 0x8 (seconds), 0x9 (minutes), 0xA (hours) and 0xB (date). Bit 7 is the field's mask bit. The value bits kept are bits 6:0 for seconds and minutes and bits 5:0 for hours and date. Every other bit reads back 0, so writing 0xFF to 0xA reads back 0xBF.
- R3: The match flag (status register 0xE, bit 3) is set on the cycle after a tick in which every unmasked field equals its counter. A tick with any unmasked field unequal, or equal counters without a tick, leaves the flag clear.
- R4: A field whose mask bit is 1 matches any counter value. With only seconds unmasked, the flag sets on ticks whose seconds equal the alarm value and on no other ticks.
- R5: With all four mask bits set, every tick sets the match flag.
- R6: The enable is bit 3 of control register 0xF, and the other bits of 0xF read 0. The summary flag (0xE bit 0) is set by a match only while the enable is 1. A match with the enable at 0 sets only the match flag.
- R7: A read of 0xE returns the flags as they were before the read. Both flags are 0 in the following cycle.
- R8: If a match tick coincides with a read of 0xE, the read returns the old flags and the new flags remain set afterwards.
- R9: irq_o is high exactly while the summary flag is set. It falls only after a clearing read.
- R10: Writes to 0xE change nothing. Reads of unmapped offsets (0x0–0x7, 0xC, 0xD) and cycles without a read return 0 on rdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse when the counters have updated |
| cur_sec_i | input | 7 | Current seconds, BCD |
| cur_min_i | input | 7 | Current minutes, BCD |
| cur_hour_i | input | 6 | Current hours, BCD |
| cur_date_i | input | 6 | Current date, BCD |
| cs_i | input | 1 | Register access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the access cycle |
| irq_o | output | 1 | Level interrupt request |

## Verification
The match function is tried in several ways:
- Fully unmasked alarms driven with one differing field, to show the comparison really looks at every field.
- Exact matches, both with the enable off and with it on, to separate the match flag from the summary flag.
- Seconds-only and all-masked alarms, to show the masks switch the compare off per field rather than globally.
- Matching counters without a tick, which must not set anything.
- A match tick landing on a clearing read, which tells "set wins" apart from "clear wins".

A behavioural model in the bench predicts the read data and irq_o for every cycle.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 8;
  localparam int N_FIELDS = 4;
  localparam int VAL_W    = DATA_W - 1;

  localparam logic [ADDR_W-1:0] ADDR_ALM_BASE = 4'h8;
  localparam logic [ADDR_W-1:0] ADDR_STATUS   = 4'hE;
  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 4'hF;

  localparam int MASK_BIT  = 7;
  localparam int IE_BIT    = 3;
  localparam int SUM_BIT   = 0;
  localparam int MATCH_BIT = 3;

  // kept value width per field: 0 sec, 1 min, 2 hour, 3 date
  function automatic int field_w(input int idx);
    return (idx < 2) ? 7 : 6;
  endfunction

  function automatic logic [DATA_W-1:0] keep_mask(input int idx);
    logic [DATA_W-1:0] m;
    m = (DATA_W'(1) << field_w(idx)) - DATA_W'(1);
    m[MASK_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import rtc_alarm_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [N_FIELDS-1:0][DATA_W-1:0]  alarm_o,
  output logic                             ie_o
);
  for (genvar f = 0; f < N_FIELDS; f++) begin : g_fld
    localparam logic [DATA_W-1:0] KEEP = keep_mask(f);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_ALM_BASE + ADDR_W'(f);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_i && addr_i == MY_ADDR) q <= wdata_i & KEEP;
    end
    assign alarm_o[f] = q;
  end

  logic ie_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ie_q <= 1'b0;
    else if (wr_i && addr_i == ADDR_CTRL) ie_q <= wdata_i[IE_BIT];
  end
  assign ie_o = ie_q;

  // R2: unused value bits of hour and date never hold a 1
  a_r2_hour_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o[2][6] == 1'b0 && alarm_o[3][6] == 1'b0);
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic [N_FIELDS-1:0][DATA_W-1:0] alarm_i,
  input  logic [N_FIELDS-1:0][VAL_W-1:0]  cur_i,
  output logic                            hit_o
);
  logic [N_FIELDS-1:0] fld_hit;
  for (genvar f = 0; f < N_FIELDS; f++) begin : g_cmp
    assign fld_hit[f] = alarm_i[f][MASK_BIT] || (alarm_i[f][VAL_W-1:0] == cur_i[f]);
  end
  assign hit_o = &fld_hit;
endmodule

// File: rtl/alarm_flags.sv
module alarm_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic ie_i,
  input  logic rd_clr_i,
  output logic match_o,
  output logic sum_o
);
  logic set_match, set_sum, match_q, sum_q;
  assign set_match = tick_i && hit_i;
  assign set_sum   = set_match && ie_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      sum_q   <= 1'b0;
    end else begin
      match_q <= set_match || (match_q && !rd_clr_i);
      sum_q   <= set_sum   || (sum_q   && !rd_clr_i);
    end
  end
  assign match_o = match_q;
  assign sum_o   = sum_q;

  a_r3_no_tick_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !match_q) |=> !match_o);
  a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !set_match) |=> (!match_o && !sum_o));
  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && hit_i) |=> match_o);
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [6:0]        cur_sec_i,
  input  logic [6:0]        cur_min_i,
  input  logic [5:0]        cur_hour_i,
  input  logic [5:0]        cur_date_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [N_FIELDS-1:0][DATA_W-1:0] alarm;
  logic [N_FIELDS-1:0][VAL_W-1:0]  cur;
  logic ie, hit, match_f, sum_f, wr, rd, rd_status;

  assign wr        = cs_i && we_i;
  assign rd        = cs_i && !we_i;
  assign rd_status = rd && addr_i == ADDR_STATUS;

  assign cur[0] = cur_sec_i;
  assign cur[1] = cur_min_i;
  assign cur[2] = {1'b0, cur_hour_i};
  assign cur[3] = {1'b0, cur_date_i};

  alarm_regs u_regs (
    .clk_i, .rst_ni, .wr_i(wr), .addr_i, .wdata_i, .alarm_o(alarm), .ie_o(ie)
  );

  alarm_match u_match (.alarm_i(alarm), .cur_i(cur), .hit_o(hit));

  alarm_flags u_flags (
    .clk_i, .rst_ni, .tick_i, .hit_i(hit), .ie_i(ie), .rd_clr_i(rd_status),
    .match_o(match_f), .sum_o(sum_f)
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (addr_i >= ADDR_ALM_BASE && addr_i < ADDR_ALM_BASE + ADDR_W'(N_FIELDS))
        rdata_o = alarm[2'(addr_i - ADDR_ALM_BASE)];
      else if (addr_i == ADDR_STATUS) begin
        rdata_o[MATCH_BIT] = match_f;
        rdata_o[SUM_BIT]   = sum_f;
      end else if (addr_i == ADDR_CTRL)
        rdata_o[IE_BIT] = ie;
    end
  end

  assign irq_o = sum_f;

  a_r6_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(ie));
  a_r9_fall_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(rd_status));
endmodule

// File: tb/sim_rtc_alarm_unit.sv
module sim_rtc_alarm_unit;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick = 0, cs = 0, we = 0;
  logic [6:0] csec = 0, cmin = 0;
  logic [5:0] chour = 0, cdate = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic irq;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  int alm [4];
  int m_ie = 0, m_match = 0, m_sum = 0;

  always #(CLK_P/2) clk = ~clk;

  rtc_alarm_unit u0 (
    .clk_i(clk), .rst_ni, .tick_i(tick), .cur_sec_i(csec), .cur_min_i(cmin),
    .cur_hour_i(chour), .cur_date_i(cdate), .cs_i(cs), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic int model_rd(input int a);
    if (a >= 8 && a <= 11) return alm[a-8];
    if (a == 14) return (m_match << 3) | m_sum;
    if (a == 15) return m_ie << 3;
    return 0;
  endfunction

  function automatic int keep(input int i);
    return (i < 2) ? 8'hFF : 8'hBF;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one clock: inputs driven after negedge, sampled at next negedge
  task automatic cyc(input string req, input bit c, input bit w, input int a, input int d,
                     input bit t, input int s, input int mi, input int h, input int dt);
    int hitv, curv[4];
    cs = c; we = w; addr = 4'(a); wdata = 8'(d); tick = t;
    csec = 7'(s); cmin = 7'(mi); chour = 6'(h); cdate = 6'(dt);
    #1;
    check(req, rdata, (c && !w) ? model_rd(a) : 0);
    @(posedge clk);
    curv[0] = s; curv[1] = mi; curv[2] = h; curv[3] = dt;
    hitv = 1;
    for (int i = 0; i < 4; i++)
      if (!alm[i][7] && (alm[i] & 8'h7F) != curv[i]) hitv = 0;
    if (c && !w && a == 14) begin m_match = 0; m_sum = 0; end
    if (t && hitv) begin m_match = 1; if (m_ie) m_sum = 1; end
    if (c && w) begin
      if (a >= 8 && a <= 11) alm[a-8] = d & keep(a-8);
      if (a == 15) m_ie = (d >> 3) & 1;
    end
    @(negedge clk);
    check("R9 irq level", irq, m_sum);
  endtask

  task automatic wr(input int a, input int d);
    cyc("R2 write", 1, 1, a, d, 0, 0, 0, 0, 0);
  endtask
  task automatic rd(input string req, input int a);
    cyc(req, 1, 0, a, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic tk(input string req, input int s, input int mi, input int h, input int dt);
    cyc(req, 0, 0, 0, 0, 1, s, mi, h, dt);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) alm[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 irq at reset", irq, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int a = 8; a < 16; a++) rd("R1 reset value", a);

    // R2 field widths and readback
    wr(8, 8'h7F); rd("R2 sec width", 8);
    wr(10, 8'hFF); rd("R2 hour width 0xBF", 10);
    wr(11, 8'hFF); rd("R2 date width", 11);
    wr(8, 8'h30); wr(9, 8'h15); wr(10, 8'h12); wr(11, 8'h25);
    for (int a = 8; a < 12; a++) rd("R2 readback", a);

    // R10 unmapped and write to status ignored
    rd("R10 unmapped 0x3", 3); rd("R10 unmapped 0xC", 12); rd("R10 unmapped 0xD", 13);
    wr(14, 8'hFF); rd("R10 status write ignored", 14);

    // R3 unmasked exact match
    tk("R3 date differs", 8'h30, 8'h15, 8'h12, 8'h24);
    tk("R3 min differs", 8'h30, 8'h16, 8'h12, 8'h25);
    rd("R3 no flag on mismatch", 14);
    cyc("R3 match without tick", 0, 0, 0, 0, 0, 8'h30, 8'h15, 8'h12, 8'h25);
    rd("R3 no flag without tick", 14);
    tk("R3 match tick", 8'h30, 8'h15, 8'h12, 8'h25);
    rd("R6 match flag only, enable off", 14);
    rd("R7 cleared after read", 14);

    // R6 enable
    wr(15, 8'hFF); rd("R6 control reads bit3 only", 15);
    tk("R6 match with enable", 8'h30, 8'h15, 8'h12, 8'h25);
    cyc("R9 irq holds", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rd("R7 status both flags", 14);
    rd("R7 both cleared", 14);

    // R4 seconds only
    wr(9, 8'h80); wr(10, 8'h80); wr(11, 8'h80); wr(8, 8'h05);
    tk("R4 sec differs", 8'h06, 8'h33, 8'h07, 8'h11);
    rd("R4 no flag", 14);
    tk("R4 sec equal other fields random", 8'h05, 8'h59, 8'h23, 8'h31);
    rd("R4 flag set", 14);

    // R5 all masked
    wr(8, 8'h80);
    for (int k = 0; k < 3; k++) begin
      tk("R5 every tick", k, 1, 2, 3);
      rd("R5 flag per tick", 14);
    end

    // R8 set wins over clear
    tk("R8 first match", 8'h00, 0, 0, 1);
    cyc("R8 read with tick", 1, 0, 14, 0, 1, 8'h01, 0, 0, 1);
    rd("R8 flag kept", 14);
    wr(15, 0);
    tk("R6 enable off again", 8'h02, 0, 0, 1);
    rd("R6 sum stays clear", 14);
    rd("R7 final clear", 14);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule